// File: doc/BRIEF.md
# Mode-configurable PLD output macrocell

This block is one output cell of a small sum-of-products logic array. It receives eight product terms from the AND plane and forms an OR sum with a selectable polarity. It then drives a tri-state pin model as a value plus an enable, and returns one feedback bit to the array. A two-bit global mode and three per-cell configuration bits choose one of four behaviours for the cell:

- a registered output;
- a combinatorial I/O;
- a combinatorial output;
- a dedicated input.

The cell's position in the row (outer, centre or other) is fixed by a parameter and removes some of these options in certain modes.

The global mode sets two things. It sets how many product terms reach the sum: either all eight, or seven with the highest term used as the output enable. It also sets where the enable comes from: always on, always off, the reserved product term, or the shared active-low enable pin. A registered cell drives the inverted state of its flip-flop. Because the flip-flop clears on reset, a registered pin reads high at power-up.

Top module: `pld_macrocell`

## Requirements
- R1: Mode codes are 2'b00 simple, 2'b01 complex and 2'b10 registered. Code 2'b11 gives exactly the outputs of code 2'b00.
- R2: In registered mode with cfg_reg_i=1 and cfg_in_i=0:
  - each rising clock loads the flip-flop with (OR of pt_i[7:0]) XOR cfg_inv_i;
  - pin_o is the inverse of the flip-flop;
  - pin_oe_o is the inverse of oe_ni.
- R3: In registered mode with cfg_reg_i=0 and cfg_in_i=0:
  - pin_o is (OR of pt_i[6:0]) XOR cfg_inv_i;
  - pin_oe_o equals pt_i[7];
  - fb_o equals pin_i.
- R4: A dedicated-input cell drives pin_oe_o=0 and fb_o=pin_i. A cell is a dedicated input when cfg_in_i=1 in registered mode, or in simple mode at a non-centre position.
- R5: In complex mode, whatever the values of cfg_reg_i and cfg_in_i:
  - pin_o is (OR of pt_i[6:0]) XOR cfg_inv_i;
  - pin_oe_o equals pt_i[7];
  - fb_o is pin_i, except at the outer position, where fb_o is 0.
- R6: In simple mode, pin_o is (OR of pt_i[7:0]) XOR cfg_inv_i. A non-input cell has pin_oe_o=1. The centre cell ignores cfg_in_i, always has pin_oe_o=1 and drives fb_o=0.
- R7: While rst_ni is low the flip-flop is 0. A registered cell then shows pin_o=1 and fb_o=0.
- R8: A registered cell's fb_o equals the flip-flop state, which is always the inverse of its pin_o.
- R9: cfg_inv_i=1 inverts the sum term on both paths: the combinatorial output and the flip-flop input.
- R10: The flip-flop samples on every clock in every mode. A registered cell that returns from another mode shows the value captured on the last clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the flip-flop |
| pt_i | input | 8 | Product terms from the AND plane; bit 7 is the enable term |
| oe_ni | input | 1 | Global active-low output-enable pin |
| mode_i | input | 2 | Global mode code |
| cfg_reg_i | input | 1 | Cell is registered (registered mode only) |
| cfg_in_i | input | 1 | Cell is a dedicated input |
| cfg_inv_i | input | 1 | Sum polarity inversion |
| pin_i | input | 1 | Value seen on the pad |
| pin_o | output | 1 | Value driven to the pad |
| pin_oe_o | output | 1 | Pad driver enable |
| fb_o | output | 1 | Feedback to the AND plane |

## Verification
Two things can happen in the same cycle: the flip-flop captures new data, and the mode switches the output path away from the flip-flop. The bench provokes this by changing the mode and the product terms together just before a rising edge. It then checks two things: the pin follows the new combinatorial route immediately, and on return to registered mode the pin shows the value captured during the excursion. The same edge-plus-enable overlap is checked by toggling oe_ni while registered data changes. The enable must follow oe_ni at once, and the data must move only at the clock.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
  typedef enum logic [1:0] {
    MODE_SIMPLE  = 2'b00,
    MODE_COMPLEX = 2'b01,
    MODE_REG     = 2'b10,
    MODE_RSVD    = 2'b11
  } mc_mode_e;

  typedef enum logic [1:0] {
    POS_OTHER  = 2'd0,
    POS_OUTER  = 2'd1,
    POS_CENTRE = 2'd2
  } mc_pos_e;

  typedef enum logic [1:0] {
    OE_OFF  = 2'd0,
    OE_ON   = 2'd1,
    OE_TERM = 2'd2,
    OE_PIN  = 2'd3
  } oe_src_e;

  typedef enum logic [1:0] {
    FB_NONE = 2'd0,
    FB_PIN  = 2'd1,
    FB_REG  = 2'd2
  } fb_src_e;

  typedef struct packed {
    logic    sum_all;
    logic    out_reg;
    oe_src_e oe_src;
    fb_src_e fb_src;
  } route_t;
endpackage

// File: rtl/mc_route_dec.sv
module mc_route_dec
  import pld_mc_pkg::*;
#(
  parameter mc_pos_e CELL_POS = POS_OTHER
) (
  input  logic [1:0] mode_i,
  input  logic       cfg_reg_i,
  input  logic       cfg_in_i,
  output route_t     route_o
);
  localparam logic IS_OUTER  = (CELL_POS == POS_OUTER);
  localparam logic IS_CENTRE = (CELL_POS == POS_CENTRE);

  mc_mode_e mode;
  assign mode = mc_mode_e'(mode_i);

  always_comb begin
    route_o = '{sum_all: 1'b1, out_reg: 1'b0, oe_src: OE_ON, fb_src: FB_PIN};
    unique case (mode)
      MODE_REG: begin
        if (cfg_in_i) begin
          route_o.oe_src = OE_OFF;
        end else if (cfg_reg_i) begin
          route_o.out_reg = 1'b1;
          route_o.oe_src  = OE_PIN;
          route_o.fb_src  = FB_REG;
        end else begin
          route_o.sum_all = 1'b0;
          route_o.oe_src  = OE_TERM;
        end
      end
      MODE_COMPLEX: begin
        route_o.sum_all = 1'b0;
        route_o.oe_src  = OE_TERM;
        route_o.fb_src  = IS_OUTER ? FB_NONE : FB_PIN;
      end
      default: begin // simple, and the reserved code
        if (IS_CENTRE) begin
          route_o.fb_src = FB_NONE;
        end else if (cfg_in_i) begin
          route_o.oe_src = OE_OFF;
        end
      end
    endcase
  end
endmodule

// File: rtl/mc_sum_term.sv
module mc_sum_term #(
  parameter int N_PT = 8
) (
  input  logic [N_PT-1:0] pt_i,
  input  logic            sum_all_i,
  input  logic            inv_i,
  output logic            sum_o,
  output logic            oe_term_o
);
  localparam int OE_IDX = N_PT - 1;

  logic [N_PT-1:0] mask;

  for (genvar g = 0; g < N_PT; g++) begin : g_mask
    if (g == OE_IDX) begin : g_oe
      assign mask[g] = sum_all_i;
    end else begin : g_sum
      assign mask[g] = 1'b1;
    end
  end

  assign sum_o     = (|(pt_i & mask)) ^ inv_i;
  assign oe_term_o = pt_i[OE_IDX];
endmodule

// File: rtl/mc_state_reg.sv
module mc_state_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pld_mc_pkg::*;
#(
  parameter int      N_PT     = 8,
  parameter mc_pos_e CELL_POS = POS_OTHER
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_PT-1:0] pt_i,
  input  logic            oe_ni,
  input  logic [1:0]      mode_i,
  input  logic            cfg_reg_i,
  input  logic            cfg_in_i,
  input  logic            cfg_inv_i,
  input  logic            pin_i,
  output logic            pin_o,
  output logic            pin_oe_o,
  output logic            fb_o
);
  route_t route;
  logic   sum, oe_term, d_full, q;

  mc_route_dec #(.CELL_POS(CELL_POS)) u_dec (
    .mode_i   (mode_i),
    .cfg_reg_i(cfg_reg_i),
    .cfg_in_i (cfg_in_i),
    .route_o  (route)
  );

  mc_sum_term #(.N_PT(N_PT)) u_sum (
    .pt_i     (pt_i),
    .sum_all_i(route.sum_all),
    .inv_i    (cfg_inv_i),
    .sum_o    (sum),
    .oe_term_o(oe_term)
  );

  // register D always sees the full-width sum, independent of route
  mc_sum_term #(.N_PT(N_PT)) u_dsum (
    .pt_i     (pt_i),
    .sum_all_i(1'b1),
    .inv_i    (cfg_inv_i),
    .sum_o    (d_full),
    .oe_term_o()
  );

  mc_state_reg u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (d_full),
    .q_o   (q)
  );

  assign pin_o = route.out_reg ? ~q : sum;

  always_comb begin
    unique case (route.oe_src)
      OE_OFF:  pin_oe_o = 1'b0;
      OE_ON:   pin_oe_o = 1'b1;
      OE_TERM: pin_oe_o = oe_term;
      default: pin_oe_o = ~oe_ni;
    endcase
    unique case (route.fb_src)
      FB_PIN:  fb_o = pin_i;
      FB_REG:  fb_o = q;
      default: fb_o = 1'b0;
    endcase
  end

  // checks
  logic reg_cell, in_cell, armed_q;
  assign reg_cell = (mode_i == 2'b10) && cfg_reg_i && !cfg_in_i;
  assign in_cell  = ((mode_i == 2'b10) && cfg_in_i) ||
                    (!mode_i[0] && (mode_i != 2'b10) && cfg_in_i && (CELL_POS != POS_CENTRE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assert_reg_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && reg_cell) |-> (pin_o == ~($past(|pt_i) ^ $past(cfg_inv_i))));

  assert_reg_oe_pin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_cell |-> (pin_oe_o == !oe_ni));

  assert_input_oe_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_cell |-> (!pin_oe_o && fb_o == pin_i));

  assert_complex_oe_term_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01) |-> (pin_oe_o == pt_i[N_PT-1]));

  assert_outer_no_fb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 2'b01) && CELL_POS == POS_OUTER) |-> !fb_o);

  assert_centre_fixed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i[0] && (mode_i != 2'b10) && CELL_POS == POS_CENTRE) |-> (pin_oe_o && !fb_o));

  assert_reg_fb_inverse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_cell |-> (fb_o == !pin_o));
endmodule

// File: tb/sim_pld_macrocell.sv
`timescale 1ns/1ps
module sim_pld_macrocell;
  import pld_mc_pkg::*;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pt_i = '0;
  logic       oe_ni = 1'b1;
  logic [1:0] mode_i = 2'b10;
  logic       cfg_reg_i = 1'b1, cfg_in_i = 1'b0, cfg_inv_i = 1'b0, pin_i = 1'b0;
  logic       p0, e0, f0, p1, e1, f1, p2, e2, f2;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #5 clk_i = ~clk_i;

  pld_macrocell #(.CELL_POS(POS_OTHER)) u0 (.clk_i, .rst_ni, .pt_i, .oe_ni, .mode_i,
    .cfg_reg_i, .cfg_in_i, .cfg_inv_i, .pin_i, .pin_o(p0), .pin_oe_o(e0), .fb_o(f0));
  pld_macrocell #(.CELL_POS(POS_OUTER)) u1 (.clk_i, .rst_ni, .pt_i, .oe_ni, .mode_i,
    .cfg_reg_i, .cfg_in_i, .cfg_inv_i, .pin_i, .pin_o(p1), .pin_oe_o(e1), .fb_o(f1));
  pld_macrocell #(.CELL_POS(POS_CENTRE)) u2 (.clk_i, .rst_ni, .pt_i, .oe_ni, .mode_i,
    .cfg_reg_i, .cfg_in_i, .cfg_inv_i, .pin_i, .pin_o(p2), .pin_oe_o(e2), .fb_o(f2));

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  // apply inputs at negedge, settle
  task automatic put(input logic [1:0] m, input logic r, input logic in, input logic inv,
                     input logic [7:0] pt, input logic oen, input logic pin);
    @(negedge clk_i);
    mode_i = m; cfg_reg_i = r; cfg_in_i = in; cfg_inv_i = inv;
    pt_i = pt; oe_ni = oen; pin_i = pin;
    #1;
  endtask

  task automatic t_reset;
    #12;
    chk("R7 reset pin high", p0, 1'b1);
    chk("R7 reset fb low", f0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R7 after release pin high", p0, 1'b1);
  endtask

  task automatic t_reg_cell;
    put(2'b10, 1, 0, 0, 8'h01, 1'b1, 1'b0);
    chk("R7 before edge pin holds", p0, 1'b1);
    chk("R2 oe follows pin (off)", e0, 1'b0);
    @(posedge clk_i); #2;
    chk("R2 captured pt0 pin", p0, 1'b0);
    chk("R8 fb is state", f0, 1'b1);
    put(2'b10, 1, 0, 0, 8'h80, 1'b0, 1'b0);
    chk("R2 oe on at once", e0, 1'b1);
    chk("R2 data waits for edge", p0, 1'b0);
    @(posedge clk_i); #2;
    chk("R2 all eight terms summed", p0, 1'b0);
    put(2'b10, 1, 0, 0, 8'h00, 1'b0, 1'b1);
    @(posedge clk_i); #2;
    chk("R2 zero sum pin high", p0, 1'b1);
    chk("R8 fb low", f0, 1'b0);
  endtask

  task automatic t_reg_comb;
    put(2'b10, 0, 0, 0, 8'h80, 1'b1, 1'b1);
    chk("R3 pt7 excluded from sum", p0, 1'b0);
    chk("R3 oe from pt7", e0, 1'b1);
    chk("R3 fb from pin", f0, 1'b1);
    put(2'b10, 0, 0, 0, 8'h40, 1'b0, 1'b0);
    chk("R3 pt6 in sum", p0, 1'b1);
    chk("R3 oe term low", e0, 1'b0);
    chk("R3 fb pin low", f0, 1'b0);
  endtask

  task automatic t_input;
    put(2'b10, 1, 1, 0, 8'hFF, 1'b0, 1'b1);
    chk("R4 reg-mode input oe off", e0, 1'b0);
    chk("R4 reg-mode input fb", f0, 1'b1);
    put(2'b00, 0, 1, 0, 8'hFF, 1'b0, 1'b1);
    chk("R4 simple input oe off", e0, 1'b0);
    chk("R4 simple input fb", f0, 1'b1);
    chk("R4 outer simple input oe off", e1, 1'b0);
    chk("R6 centre ignores input cfg oe", e2, 1'b1);
    chk("R6 centre fb zero", f2, 1'b0);
  endtask

  task automatic t_complex;
    put(2'b01, 1, 1, 0, 8'h80, 1'b1, 1'b1);
    chk("R5 pt7 not in sum", p0, 1'b0);
    chk("R5 oe from pt7", e0, 1'b1);
    chk("R5 other fb pin", f0, 1'b1);
    chk("R5 outer fb none", f1, 1'b0);
    chk("R5 centre fb pin", f2, 1'b1);
    put(2'b01, 0, 0, 1, 8'h02, 1'b1, 1'b0);
    chk("R9 complex inverted", p0, 1'b0);
    chk("R5 oe term low", e1, 1'b0);
  endtask

  task automatic t_simple;
    put(2'b00, 0, 0, 0, 8'h80, 1'b1, 1'b1);
    chk("R6 pt7 in sum", p0, 1'b1);
    chk("R6 oe on", e0, 1'b1);
    chk("R6 other fb pin", f0, 1'b1);
    chk("R6 centre out", p2, 1'b1);
    put(2'b00, 0, 0, 1, 8'h00, 1'b1, 1'b0);
    chk("R9 simple polarity", p0, 1'b1);
    put(2'b11, 0, 0, 0, 8'h80, 1'b1, 1'b1);
    chk("R1 code 11 sum", p0, 1'b1);
    chk("R1 code 11 oe", e0, 1'b1);
    chk("R1 code 11 centre fb", f2, 1'b0);
    put(2'b11, 0, 1, 0, 8'h00, 1'b1, 1'b1);
    chk("R1 code 11 input oe off", e0, 1'b0);
  endtask

  task automatic t_reg_polarity;
    put(2'b10, 1, 0, 1, 8'h00, 1'b0, 1'b0);
    @(posedge clk_i); #2;
    chk("R9 inverted D zero sum", p0, 1'b0);
    chk("R8 fb high", f0, 1'b1);
  endtask

  task automatic t_mode_switch;
    put(2'b10, 1, 0, 0, 8'h00, 1'b0, 1'b0);
    @(posedge clk_i); #2;
    chk("R10 start pin high", p0, 1'b1);
    put(2'b01, 1, 0, 0, 8'h01, 1'b0, 1'b1);
    chk("R10 comb route at once", p0, 1'b1);
    chk("R5 fb switched to pin", f0, 1'b1);
    @(posedge clk_i); #2;
    put(2'b10, 1, 0, 0, 8'h00, 1'b0, 1'b0);
    chk("R10 captured in complex", p0, 1'b0);
    chk("R8 fb state", f0, 1'b1);
  endtask

  initial begin
    t_reset;
    t_reg_cell;
    t_reg_comb;
    t_input;
    t_complex;
    t_simple;
    t_reg_polarity;
    t_mode_switch;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule